// File: doc/BRIEF.md
# Parallel Panel Register Access Engine

This block masters an 8080-style parallel bus towards a display panel whose data lines are 18 bits wide. A host asks for one register operation at a time through a small request port. For a write it supplies an 8-bit register index and a 16-bit value. For a read it supplies only the index. The engine then runs the strobes and the data bus on the panel side until the transaction is complete.

A write is two bus cycles. The index goes out first with the data/command select low. The value follows with the select high. Each cycle has its own setup and hold lengths, given in clock cycles. The controller this engine serves has a normal path that can only write, so a read is built by hand. The engine sends the index, gives up the data bus, and pulses the read enable in a fixed order. It samples the bus and then ends the transaction. Those read steps are counted in time units of `UNIT_CYC` clock cycles.

Every 16-bit quantity travels in two byte lanes with an empty bit below each lane. The same layout is undone on the way back.

Top module: `panel_reg_port`

## Requirements
- R1: Out of reset and whenever busy is low, chip select, data/command select, write strobe and read enable are all high. The data bus output enable is high and the driven bus is all zeros. Busy, done and rdata are zero after reset.
- R2: A 16-bit word W is driven as bus[8:1] = W[7:0] and bus[17:10] = W[15:8], with bus[0] = bus[9] = 0. An 8-bit index is driven as the word {8'h00, index}.
- R3: A write is accepted when req_valid is high and busy is low. From the next cycle, chip select is low and four phases follow, each for its programmed count. The first is command setup: select low, write strobe low, index driven. The second is command hold: strobe high. The third is data setup: select high, strobe low, value driven. The fourth is data hold: strobe high. After that the bus returns to the idle levels. With counts 2/2/1/2 busy lasts 7 cycles.
- R4: A programmed count of zero acts as one cycle, so a write with all counts zero keeps busy high for 4 cycles.
- R5: The command-setup count is taken at acceptance and the other three counts are captured there. Changes to the timing inputs while busy do not alter the running transaction.
- R6: A read runs these steps in order, in time units U: all idle levels for 2U; select low 1U; chip select low 1U; write strobe low 1U; index driven 1U; write strobe high 3U; bus released 2U; read enable low 1U; select high 1U; read enable high 3U; read enable low 2U; read enable still low 1U; read enable high 1U. Chip select then rises. Busy lasts 20U cycles.
- R7: The bus output enable is low for exactly 2U cycles before the read enable first falls. It is never high while the read enable is low.
- R8: rdata is loaded once per read, on the last cycle of the 2U read-enable-low step, with {bus[17:10], bus[8:1]}. Bits 0 and 9 are ignored. rdata holds its value at all other times, including during writes.
- R9: Busy rises in the cycle after acceptance and falls when chip select returns high. A request presented while busy is ignored and starts no further transaction.
- R10: Done is high for exactly one cycle, the first cycle with busy low after a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_index | input | 8 | Panel register index |
| req_wdata | input | 16 | Value to write |
| t_cmd_setup | input | TW | Command setup length in cycles |
| t_cmd_hold | input | TW | Command hold length in cycles |
| t_dat_setup | input | TW | Data setup length in cycles |
| t_dat_hold | input | TW | Data hold length in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 16 | Last value read from the panel |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| pnl_dc | output | 1 | Data/command select, low = command |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read enable, active low |
| pnl_oe | output | 1 | Data bus output enable |
| pnl_dout | output | 18 | Data bus, driven value |
| pnl_din | input | 18 | Data bus, sampled value |

## Verification
The hardest case to reach is a request that arrives while the engine is in the last cycle of a transaction. There busy is still high, and one cycle later the engine takes requests again. A second hard case is a change to the timing inputs after acceptance. The stimulus pulses req_valid in the middle of a read and rewrites all four timing counts one cycle after a long write has started. A cycle-accurate queue model predicts every pin, so an extra acceptance or a stretched phase shows up on the cycle it happens. Read patterns that set only the two gap bits, and patterns that set every bit, show whether the gaps are really ignored.

// File: rtl/pnl_pkg.sv
// Shared widths, phase encoding and pin-control types for the panel
// register engine. Assumes two byte lanes, each with one gap bit below it.
package pnl_pkg;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;
    localparam int BUS_W     = NUM_LANES * (LANE_W + 1);
    localparam int IDX_W     = 8;

    typedef enum logic [4:0] {
        PH_IDLE,
        PH_WC_SET, PH_WC_HLD, PH_WD_SET, PH_WD_HLD,
        PH_R_PRE, PH_R_DC, PH_R_SEL, PH_R_STB, PH_R_IDX, PH_R_LAT,
        PH_R_TURN, PH_R_ENL, PH_R_DCH, PH_R_ENH, PH_R_WAIT, PH_R_POST,
        PH_R_REL
    } phase_e;

    typedef enum logic [1:0] {SRC_ZERO, SRC_IDX, SRC_VAL} src_e;

    typedef struct packed {
        logic cs_n;
        logic dc;
        logic wr_n;
        logic rd_n;
        logic oe;
        src_e src;
    } pin_ctl_t;
endpackage

// File: rtl/pnl_lane_pack.sv
// Spreads a word over the bus byte lanes. Each lane has a zero gap bit
// below it. Purely combinational.
module pnl_lane_pack
    import pnl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [BUS_W-1:0]  bus
);
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        assign bus[b*(LANE_W+1)]                = 1'b0;
        assign bus[b*(LANE_W+1)+1 +: LANE_W]    = word[b*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pnl_lane_unpack.sv
// Gathers the byte lanes of a sampled bus back into a word and drops
// the gap bits. Purely combinational.
module pnl_lane_unpack
    import pnl_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    output logic [WORD_W-1:0] word
);
    logic [NUM_LANES-1:0] gap_unused;
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        assign word[b*LANE_W +: LANE_W] = bus[b*(LANE_W+1)+1 +: LANE_W];
        assign gap_unused[b]            = bus[b*(LANE_W+1)];
    end
endmodule

// File: rtl/pnl_timer.sv
// Phase length down-counter. It is loaded with the length minus one when a
// phase starts. expired is high in the last cycle of the phase.
module pnl_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Count down to zero. A load restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pnl_seq.sv
// Transaction sequencer. It accepts a request in the idle phase, walks the
// write or read phase chain and gives each phase its length. It flags the
// read sample point and pulses done on the return to idle. Assumes
// UNIT_CYC >= 1.
module pnl_seq
    import pnl_pkg::*;
#(
    parameter int UNIT_CYC = 2,
    parameter int TW       = 6,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_read,
    input  logic [TW-1:0] t_cs_in,
    input  logic [TW-1:0] t_ch_in,
    input  logic [TW-1:0] t_ds_in,
    input  logic [TW-1:0] t_dh_in,
    input  logic          expired,
    output phase_e        phase,
    output logic          accept,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          sample,
    output logic          done
);
    localparam logic [CW-1:0] U1 = CW'(UNIT_CYC - 1);
    localparam logic [CW-1:0] U2 = CW'(2 * UNIT_CYC - 1);
    localparam logic [CW-1:0] U3 = CW'(3 * UNIT_CYC - 1);

    logic [TW-1:0] ch_q, ds_q, dh_q;
    phase_e        tgt, nxt;
    logic          adv;

    // Length minus one. A zero count acts as one cycle.
    function automatic logic [CW-1:0] cyc_m1(logic [TW-1:0] t);
        return (t == '0) ? '0 : (CW'(t) - 1'b1);
    endfunction

    // The phase that follows each phase.
    function automatic phase_e step_after(phase_e p);
        case (p)
            PH_WC_SET: return PH_WC_HLD;
            PH_WC_HLD: return PH_WD_SET;
            PH_WD_SET: return PH_WD_HLD;
            PH_R_PRE:  return PH_R_DC;
            PH_R_DC:   return PH_R_SEL;
            PH_R_SEL:  return PH_R_STB;
            PH_R_STB:  return PH_R_IDX;
            PH_R_IDX:  return PH_R_LAT;
            PH_R_LAT:  return PH_R_TURN;
            PH_R_TURN: return PH_R_ENL;
            PH_R_ENL:  return PH_R_DCH;
            PH_R_DCH:  return PH_R_ENH;
            PH_R_ENH:  return PH_R_WAIT;
            PH_R_WAIT: return PH_R_POST;
            PH_R_POST: return PH_R_REL;
            default:   return PH_IDLE;
        endcase
    endfunction

    // Pick the next phase and the length to load for it.
    always_comb begin
        accept = req_valid && (phase == PH_IDLE);
        adv    = (phase != PH_IDLE) && expired;
        nxt    = step_after(phase);
        tgt    = phase;
        load   = 1'b0;
        if (accept) begin
            tgt  = req_read ? PH_R_PRE : PH_WC_SET;
            load = 1'b1;
        end else if (adv) begin
            tgt  = nxt;
            load = (nxt != PH_IDLE);
        end
        case (tgt)
            PH_WC_SET:                      load_val = cyc_m1(t_cs_in);
            PH_WC_HLD:                      load_val = cyc_m1(ch_q);
            PH_WD_SET:                      load_val = cyc_m1(ds_q);
            PH_WD_HLD:                      load_val = cyc_m1(dh_q);
            PH_R_PRE, PH_R_TURN, PH_R_WAIT: load_val = U2;
            PH_R_LAT, PH_R_ENH:             load_val = U3;
            PH_IDLE:                        load_val = '0;
            default:                        load_val = U1;
        endcase
        sample = (phase == PH_R_WAIT) && expired;
    end

    // Phase register, captured timing and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ch_q  <= '0;
            ds_q  <= '0;
            dh_q  <= '0;
            done  <= 1'b0;
        end else begin
            phase <= tgt;
            done  <= adv && (nxt == PH_IDLE);
            if (accept) begin
                ch_q <= t_ch_in;
                ds_q <= t_ds_in;
                dh_q <= t_dh_in;
            end
        end
    end
endmodule

// File: rtl/pnl_pin_drv.sv
// Decodes the current phase into panel strobe levels and the driven bus
// value. Outputs depend only on registered state.
module pnl_pin_drv
    import pnl_pkg::*;
(
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  idx_q,
    input  logic [WORD_W-1:0] val_q,
    output logic              cs_n,
    output logic              dc,
    output logic              wr_n,
    output logic              rd_n,
    output logic              oe,
    output logic [BUS_W-1:0]  dout
);
    pin_ctl_t         ctl;
    logic [BUS_W-1:0] idx_bus, val_bus;

    pnl_lane_pack u_pack_idx (.word(WORD_W'(idx_q)), .bus(idx_bus));
    pnl_lane_pack u_pack_val (.word(val_q),          .bus(val_bus));

    // Strobe levels and bus source for each phase.
    always_comb begin
        case (phase)
            PH_WC_SET: ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_IDX};
            PH_WC_HLD: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_IDX};
            PH_WD_SET: ctl = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, SRC_VAL};
            PH_WD_HLD: ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, SRC_VAL};
            PH_R_DC:   ctl = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, SRC_ZERO};
            PH_R_SEL:  ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_ZERO};
            PH_R_STB:  ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_ZERO};
            PH_R_IDX:  ctl = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_IDX};
            PH_R_LAT:  ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_IDX};
            PH_R_TURN: ctl = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, SRC_ZERO};
            PH_R_ENL:  ctl = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, SRC_ZERO};
            PH_R_DCH:  ctl = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, SRC_ZERO};
            PH_R_ENH:  ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO};
            PH_R_WAIT: ctl = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, SRC_ZERO};
            PH_R_POST: ctl = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, SRC_ZERO};
            PH_R_REL:  ctl = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO};
            default:   ctl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, SRC_ZERO};
        endcase
    end

    // Select the driven bus value.
    always_comb begin
        case (ctl.src)
            SRC_IDX: dout = idx_bus;
            SRC_VAL: dout = val_bus;
            default: dout = '0;
        endcase
    end

    assign cs_n = ctl.cs_n;
    assign dc   = ctl.dc;
    assign wr_n = ctl.wr_n;
    assign rd_n = ctl.rd_n;
    assign oe   = ctl.oe;
endmodule

// File: rtl/panel_reg_port.sv
// Panel register access engine (top). It takes one host request at a time
// and runs a two-cycle register write or a hand-sequenced register read on
// an 18-bit 8080-style bus. Assumes pnl_din is stable around the sample point.
module panel_reg_port
    import pnl_pkg::*;
#(
    parameter int UNIT_CYC = 2,
    parameter int TW       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [TW-1:0]     t_cmd_setup,
    input  logic [TW-1:0]     t_cmd_hold,
    input  logic [TW-1:0]     t_dat_setup,
    input  logic [TW-1:0]     t_dat_hold,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              pnl_cs_n,
    output logic              pnl_dc,
    output logic              pnl_wr_n,
    output logic              pnl_rd_n,
    output logic              pnl_oe,
    output logic [BUS_W-1:0]  pnl_dout,
    input  logic [BUS_W-1:0]  pnl_din
);
    localparam int UW = $clog2(3 * UNIT_CYC + 1);
    localparam int CW = (TW > UW) ? TW : UW;

    phase_e            phase;
    logic              accept, t_load, t_exp, sample;
    logic [CW-1:0]     t_val;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] val_q, rd_word, rdata_q;

    pnl_seq #(.UNIT_CYC(UNIT_CYC), .TW(TW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .t_cs_in(t_cmd_setup), .t_ch_in(t_cmd_hold),
        .t_ds_in(t_dat_setup), .t_dh_in(t_dat_hold),
        .expired(t_exp), .phase(phase), .accept(accept), .load(t_load),
        .load_val(t_val), .sample(sample), .done(done)
    );

    pnl_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
        .expired(t_exp)
    );

    pnl_pin_drv u_pins (
        .phase(phase), .idx_q(idx_q), .val_q(val_q),
        .cs_n(pnl_cs_n), .dc(pnl_dc), .wr_n(pnl_wr_n), .rd_n(pnl_rd_n),
        .oe(pnl_oe), .dout(pnl_dout)
    );

    pnl_lane_unpack u_unpack (.bus(pnl_din), .word(rd_word));

    // Hold the request operands for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            val_q <= '0;
        end else if (accept) begin
            idx_q <= req_index;
            val_q <= req_wdata;
        end
    end

    // Capture read data at the sample point only.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (sample) rdata_q <= rd_word;
    end

    assign busy  = (phase != PH_IDLE);
    assign rdata = rdata_q;
endmodule

// File: rtl/pnl_chk.sv
// Protocol checker for panel_reg_port, bound to every instance. It watches
// only the ports of the top.
module pnl_chk
    import pnl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] rdata,
    input logic              pnl_cs_n,
    input logic              pnl_dc,
    input logic              pnl_wr_n,
    input logic              pnl_rd_n,
    input logic              pnl_oe,
    input logic [BUS_W-1:0]  pnl_dout
);
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pnl_cs_n && pnl_dc && pnl_wr_n && pnl_rd_n && pnl_oe && (pnl_dout == '0)))
        else $error("idle levels"); // R1
    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_oe |-> (!pnl_dout[0] && !pnl_dout[LANE_W+1]))
        else $error("gap bit driven"); // R2
    AST_WR_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_wr_n |-> (!pnl_cs_n && pnl_oe))
        else $error("write strobe outside select"); // R3
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rd_n |-> !pnl_oe)
        else $error("bus driven during read enable"); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (!pnl_oe && !pnl_rd_n && pnl_dc))
        else $error("rdata moved outside sample"); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy)
        else $error("request not taken"); // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R10
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done)
        else $error("busy fell without done"); // R10
endmodule

bind panel_reg_port pnl_chk u_pnl_chk (.*);

// File: tb/test_panel_reg_port.sv
// Bench: a queue of expected per-cycle pin frames, filled on acceptance from
// the requirements and compared on every clock, plus directed checks.
module test_panel_reg_port;
    localparam int U  = 2;
    localparam int TW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [7:0] req_index = '0;
    logic [15:0] req_wdata = '0;
    logic [TW-1:0] t_cs = 6'd2, t_ch = 6'd2, t_ds = 6'd1, t_dh = 6'd2;
    logic busy, done, pnl_cs_n, pnl_dc, pnl_wr_n, pnl_rd_n, pnl_oe;
    logic [15:0] rdata;
    logic [17:0] pnl_dout, pnl_din = '0;

    panel_reg_port #(.UNIT_CYC(U), .TW(TW)) i_panel_reg_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_index(req_index), .req_wdata(req_wdata),
        .t_cmd_setup(t_cs), .t_cmd_hold(t_ch), .t_dat_setup(t_ds), .t_dat_hold(t_dh),
        .busy(busy), .done(done), .rdata(rdata),
        .pnl_cs_n(pnl_cs_n), .pnl_dc(pnl_dc), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_oe(pnl_oe), .pnl_dout(pnl_dout), .pnl_din(pnl_din)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic cs_n; logic dc; logic wr_n; logic rd_n; logic oe;
        logic [17:0] dout; logic bsy; logic dn; logic [15:0] rd;
    } frm_t;

    frm_t fq[$];
    frm_t exp_f;
    logic [15:0] m_rd = '0;
    int n_run = 0, n_fail = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;

    function automatic logic [17:0] bus_of(logic [15:0] v);
        return {v[15:8], 1'b0, v[7:0], 1'b0};
    endfunction

    function automatic int eff(logic [TW-1:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    function automatic frm_t mk(logic c, logic d, logic w, logic r, logic o,
                                logic [17:0] b, logic bz, logic dn, logic [15:0] rv);
        frm_t f;
        f = '{c, d, w, r, o, b, bz, dn, rv};
        return f;
    endfunction

    task automatic push_n(frm_t f, int n);
        for (int i = 0; i < n; i++) fq.push_back(f);
    endtask

    // Reference model: build the frames on acceptance, pop one per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            fq.delete();
            m_rd  = '0;
            exp_f = mk(1, 1, 1, 1, 1, '0, 0, 0, '0);
        end else begin
            if (fq.size() == 0 && req_valid) begin
                logic [17:0] bi;
                bi = bus_of({8'h00, req_index});
                if (req_read) begin
                    push_n(mk(1, 1, 1, 1, 1, '0, 1, 0, m_rd), 2*U);
                    push_n(mk(1, 0, 1, 1, 1, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 0, 1, 1, 1, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 0, 0, 1, 1, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 0, 0, 1, 1, bi, 1, 0, m_rd), U);
                    push_n(mk(0, 0, 1, 1, 1, bi, 1, 0, m_rd), 3*U);
                    push_n(mk(0, 0, 1, 1, 0, '0, 1, 0, m_rd), 2*U);
                    push_n(mk(0, 0, 1, 0, 0, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 1, 1, 0, 0, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 1, 1, 1, 0, '0, 1, 0, m_rd), 3*U);
                    push_n(mk(0, 1, 1, 0, 0, '0, 1, 0, m_rd), 2*U);
                    m_rd = {pnl_din[17:10], pnl_din[8:1]};
                    push_n(mk(0, 1, 1, 0, 0, '0, 1, 0, m_rd), U);
                    push_n(mk(0, 1, 1, 1, 0, '0, 1, 0, m_rd), U);
                end else begin
                    push_n(mk(0, 0, 0, 1, 1, bi, 1, 0, m_rd), eff(t_cs));
                    push_n(mk(0, 0, 1, 1, 1, bi, 1, 0, m_rd), eff(t_ch));
                    push_n(mk(0, 1, 0, 1, 1, bus_of(req_wdata), 1, 0, m_rd), eff(t_ds));
                    push_n(mk(0, 1, 1, 1, 1, bus_of(req_wdata), 1, 0, m_rd), eff(t_dh));
                end
                push_n(mk(1, 1, 1, 1, 1, '0, 0, 1, m_rd), 1);
            end
            if (fq.size() != 0) exp_f = fq.pop_front();
            else                exp_f = mk(1, 1, 1, 1, 1, '0, 0, 0, m_rd);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            frm_t got;
            got = mk(pnl_cs_n, pnl_dc, pnl_wr_n, pnl_rd_n, pnl_oe, pnl_dout, busy, done, rdata);
            n_run++;
            if (got !== exp_f) begin
                n_fail++;
                $display("FAIL %s per-cycle pins: actual %h expected %h", tag, got, exp_f);
            end
        end
    end

    task automatic chk(string r, int act, int expv, string what);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Issue one request, follow it to the end and check the directed items.
    task automatic run(bit rd, logic [7:0] ix, logic [15:0] v, int exp_cyc,
                       string rq, bit poke, bit retime);
        int n = 0, oe_lead = 0;
        bit en_seen = 0;
        logic [15:0] exp_rd;
        tag = rq;
        exp_rd = rd ? {pnl_din[17:10], pnl_din[8:1]} : m_rd;
        req_valid = 1; req_read = rd; req_index = ix; req_wdata = v;
        @(negedge clk);
        req_valid = 0;
        while (busy) begin
            n++;
            if (!pnl_oe && pnl_rd_n && !en_seen) oe_lead++;
            if (!pnl_rd_n) en_seen = 1;
            if (!rd && !pnl_cs_n && !pnl_wr_n)
                chk("R2", int'(pnl_dout), int'(pnl_dc ? bus_of(v) : bus_of({8'h00, ix})), "packed bus");
            if (poke) begin req_valid = (n == 5); req_read = 0; req_wdata = 16'hDEAD; end
            if (retime && n == 1) begin t_cs = 1; t_ch = 1; t_ds = 1; t_dh = 1; end
            @(negedge clk);
        end
        req_valid = 0;
        chk(rq, n, exp_cyc, "busy cycles");
        chk("R10", int'(done), 1, "done at end");
        chk("R8", int'(rdata), int'(exp_rd), "rdata after transaction");
        if (rd) chk("R7", oe_lead, 2*U, "release lead before enable");
        @(negedge clk);
        chk("R10", int'(done), 0, "done second cycle");
        chk("R9", int'(busy), 0, "no extra transaction");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cmp_on = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset levels
        chk("R1", int'({pnl_cs_n, pnl_dc, pnl_wr_n, pnl_rd_n, pnl_oe}), 5'h1F, "idle strobes");
        chk("R1", int'(pnl_dout), 0, "idle bus");
        chk("R1", int'({busy, done}), 0, "idle busy/done");
        chk("R1", int'(rdata), 0, "reset rdata");
        // R3: default 2/2/1/2 write
        run(0, 8'h3C, 16'hA5C3, 7, "R3", 0, 0);
        // R4: zero counts act as one
        t_cs = 0; t_ch = 0; t_ds = 0; t_dh = 0;
        run(0, 8'hFF, 16'h0001, 4, "R4", 0, 0);
        // R5: long counts, changed after acceptance
        t_cs = 5; t_ch = 3; t_ds = 4; t_dh = 6;
        run(0, 8'h81, 16'hFFFF, 18, "R5", 0, 1);
        // R6: read, all bits set
        pnl_din = 18'h3FFFF;
        run(1, 8'h00, 16'h0, 20*U, "R6", 0, 0);
        // R8: only the gap bits set
        pnl_din = 18'h00201;
        run(1, 8'h5A, 16'h0, 20*U, "R8", 0, 0);
        // R9: request pulsed mid-read is ignored
        pnl_din = {8'h5A, 1'b1, 8'h3C, 1'b1};
        run(1, 8'h12, 16'h0, 20*U, "R9", 1, 0);
        // R8: a write leaves rdata alone
        t_cs = 2; t_ch = 2; t_ds = 1; t_dh = 2;
        run(0, 8'h07, 16'h0173, 7, "R8", 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule